// File: doc/BRIEF.md
# Protection Fault Recovery Sequencer

This block decides what a switching power controller does after a protection fault. It takes fault requests: overload, abnormal overcurrent and thermal shutdown. It also takes a strap that selects between latch-off and automatic restart, and digitized supply flags: VCC above its start threshold, VCC below its stop threshold, VCC below its reset level, brown-out and power-saving entry. From these it drives three outputs. The first enables the gate driver. The second asks the analog side to hold VCC at its bias level. The third asks the start-up source to recharge VCC.

An overload or overcurrent fault stops the drive at once and lets VCC fall. When VCC reaches its stop threshold, the block behaves according to the strap. In latch-off mode it holds the bias level until VCC collapses below reset. In restart mode it holds the bias level for a fixed delay and then starts a new charge cycle. A thermal fault instead starts repeated VCC hiccup cycles. These last until the die has cooled and VCC is back up, unless a reset-level drop, brown-out or power-saving entry clears the fault first. The hold delay is a parameter counted in clock cycles. Its default is 2 s at 250 MHz.

Top module: `prot_fault_seq`

## Requirements
- R1: Reset is synchronous and active high. After reset the block is in CHARGE: charge_req_o=1, drv_en_o=0, bias_hold_o=0. state_oh_o always has exactly one bit set, with this encoding: bit0 RUN, bit1 DISCHARGE, bit2 BIAS_HOLD, bit3 CHARGE, bit4 LATCHED, bit5 THERMAL.
- R2: In RUN, an overload or overcurrent request sampled at a clock edge moves the block to DISCHARGE at that edge. In DISCHARGE, drv_en_o, bias_hold_o and charge_req_o are all 0.
- R3: The value of auto_mode_i (1 = restart, 0 = latch-off) is captured on the edge that leaves RUN for DISCHARGE. Changes to auto_mode_i after that edge do not affect the sequence.
- R4: In DISCHARGE with latch-off captured, vcc_lo_i moves the block to LATCHED, where bias_hold_o=1. LATCHED ignores every input except vcc_rst_i.
- R5: In DISCHARGE with restart captured, vcc_lo_i moves the block to BIAS_HOLD. It stays there, with bias_hold_o=1, for exactly HOLD_CYCLES cycles and then enters CHARGE.
- R6: CHARGE asserts charge_req_o. It moves to RUN on vcc_on_i only when overload, overcurrent, thermal and brown-out inputs are all low.
- R7: A thermal request in RUN or CHARGE moves the block to THERMAL. In RUN it takes precedence over overload and overcurrent.
- R8: In THERMAL, charge_req_o becomes 1 on the edge after vcc_lo_i is sampled and returns to 0 on the edge after vcc_on_i is sampled. It is 0 on entry.
- R9: THERMAL goes to CHARGE on brown-out or power-saving entry. Otherwise it goes to RUN when vcc_on_i and temp_ok_i are high and overload, overcurrent, thermal and brown-out are all low.
- R10: vcc_rst_i sampled in any state moves the block to CHARGE, with priority over every other input.
- R11: drv_en_o is 1 exactly when the block is in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovld_req_i | input | 1 | Overload timer expired |
| ocp_req_i | input | 1 | Abnormal overcurrent count reached |
| therm_req_i | input | 1 | Die temperature above shutdown threshold |
| temp_ok_i | input | 1 | Die temperature below threshold minus hysteresis |
| auto_mode_i | input | 1 | 1 = automatic restart, 0 = latch-off |
| vcc_on_i | input | 1 | VCC above start threshold |
| vcc_lo_i | input | 1 | VCC below stop threshold |
| vcc_rst_i | input | 1 | VCC below reset level |
| brown_out_i | input | 1 | Line brown-out fault |
| pwr_save_i | input | 1 | Power-saving mode entered |
| drv_en_o | output | 1 | Gate drive enable |
| bias_hold_o | output | 1 | Hold VCC at bias level |
| charge_req_o | output | 1 | Start VCC charge from start-up source |
| state_oh_o | output | 6 | One-hot state for debug |

## Verification
Every output is decoded from registered state, so a wrong state shows at the ports one cycle after the edge that caused it. drv_en_o, bias_hold_o and charge_req_o reveal the state class, and state_oh_o names the exact state. A miscaptured mode shows up only when VCC reaches the stop threshold, because only then do LATCHED and BIAS_HOLD diverge. An off-by-one hold counter shows up only when BIAS_HOLD ends. The bench compares a cycle model with all four outputs on every cycle, so each of these errors is caught the first cycle it reaches a port.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_DISCH   = 3'd1,
        ST_BHOLD   = 3'd2,
        ST_CHARGE  = 3'd3,
        ST_LATCHED = 3'd4,
        ST_THERM   = 3'd5
    } fseq_state_e;

    localparam int unsigned N_STATES = 6;

    // Condensed request vector seen by the controller
    typedef struct packed {
        logic rst_lvl;     // VCC under reset level
        logic prot;        // overload or overcurrent
        logic therm;       // thermal shutdown request
        logic therm_clr;   // brown-out or power saving
        logic all_clear;   // no fault of any kind present
        logic vcc_on;
        logic vcc_lo;
        logic cool;        // temperature back under hysteresis point
    } fseq_req_t;

    typedef struct packed {
        logic drv_en;
        logic bias_hold;
        logic charge_req;
    } fseq_out_t;

    function automatic logic holds_bias(fseq_state_e s);
        return (s == ST_BHOLD) || (s == ST_LATCHED);
    endfunction

endpackage

// File: rtl/fseq_req_merge.sv
module fseq_req_merge
    import fseq_pkg::*;
(
    input  logic      ovld_req,
    input  logic      ocp_req,
    input  logic      therm_req,
    input  logic      temp_ok,
    input  logic      vcc_on,
    input  logic      vcc_lo,
    input  logic      vcc_rst,
    input  logic      brown_out,
    input  logic      pwr_save,
    output fseq_req_t req
);
    always_comb begin
        req.rst_lvl   = vcc_rst;
        req.prot      = ovld_req | ocp_req;
        req.therm     = therm_req;
        req.therm_clr = brown_out | pwr_save;
        req.all_clear = ~(ovld_req | ocp_req | therm_req | brown_out);
        req.vcc_on    = vcc_on;
        req.vcc_lo    = vcc_lo;
        req.cool      = temp_ok;
    end
endmodule

// File: rtl/fseq_hold_timer.sv
module fseq_hold_timer #(
    parameter int unsigned HOLD_CYCLES = 500_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign done = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST); // R5
    AST_TIMER_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
    import fseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  fseq_req_t   req,
    input  logic        auto_mode,
    input  logic        hold_done,
    output fseq_state_e state_q,
    output logic        mode_auto_q
);
    fseq_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (req.rst_lvl) begin
            state_d = ST_CHARGE;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (req.therm)      state_d = ST_THERM;
                    else if (req.prot)  state_d = ST_DISCH;
                end
                ST_DISCH: begin
                    if (req.vcc_lo) state_d = mode_auto_q ? ST_BHOLD : ST_LATCHED;
                end
                ST_BHOLD: begin
                    if (hold_done) state_d = ST_CHARGE;
                end
                ST_CHARGE: begin
                    if (req.therm)                           state_d = ST_THERM;
                    else if (req.vcc_on && req.all_clear)    state_d = ST_RUN;
                end
                ST_LATCHED: state_d = ST_LATCHED;
                ST_THERM: begin
                    if (req.therm_clr)                                  state_d = ST_CHARGE;
                    else if (req.vcc_on && req.cool && req.all_clear)   state_d = ST_RUN;
                end
                default: state_d = ST_CHARGE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_CHARGE;
            mode_auto_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && state_d == ST_DISCH) begin
                mode_auto_q <= auto_mode;
            end
        end
    end

    AST_FAULT_STOPS_RUN: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && req.prot && !req.therm && !req.rst_lvl)
        |=> (state_q == ST_DISCH)); // R2
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_RUN) |=> $stable(mode_auto_q)); // R3
    AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LATCHED && !req.rst_lvl) |=> (state_q == ST_LATCHED)); // R4
    AST_HOLD_NO_EARLY_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BHOLD && !hold_done && !req.rst_lvl) |=> (state_q == ST_BHOLD)); // R5
    AST_CHARGE_GATED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHARGE && !req.all_clear) |=> (state_q != ST_RUN)); // R6
    AST_THERM_FIRST: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && req.therm && !req.rst_lvl) |=> (state_q == ST_THERM)); // R7
    AST_RESET_LEVEL: assert property (@(posedge clk) disable iff (rst)
        req.rst_lvl |=> (state_q == ST_CHARGE)); // R10
endmodule

// File: rtl/fseq_out_dec.sv
module fseq_out_dec
    import fseq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  fseq_state_e         state_q,
    input  logic                vcc_on,
    input  logic                vcc_lo,
    output fseq_out_t           outs,
    output logic [N_STATES-1:0] state_oh
);
    logic hic_q;   // hiccup charge phase while in thermal shutdown

    always_ff @(posedge clk) begin
        if (rst || state_q != ST_THERM) begin
            hic_q <= 1'b0;
        end else if (vcc_on) begin
            hic_q <= 1'b0;
        end else if (vcc_lo) begin
            hic_q <= 1'b1;
        end
    end

    for (genvar i = 0; i < N_STATES; i++) begin : g_oh
        assign state_oh[i] = (state_q == fseq_state_e'(3'(i)));
    end

    always_comb begin
        outs.drv_en     = (state_q == ST_RUN);
        outs.bias_hold  = holds_bias(state_q);
        outs.charge_req = (state_q == ST_CHARGE) || (state_q == ST_THERM && hic_q);
    end

    AST_HICCUP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_THERM && vcc_on) |=> !hic_q); // R8
    AST_HICCUP_SET: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_THERM && vcc_lo && !vcc_on) |=> hic_q); // R8
    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot(state_oh)); // R1
endmodule

// File: rtl/prot_fault_seq.sv
module prot_fault_seq
    import fseq_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 500_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ovld_req_i,
    input  logic       ocp_req_i,
    input  logic       therm_req_i,
    input  logic       temp_ok_i,
    input  logic       auto_mode_i,
    input  logic       vcc_on_i,
    input  logic       vcc_lo_i,
    input  logic       vcc_rst_i,
    input  logic       brown_out_i,
    input  logic       pwr_save_i,
    output logic       drv_en_o,
    output logic       bias_hold_o,
    output logic       charge_req_o,
    output logic [5:0] state_oh_o
);
    fseq_req_t   req;
    fseq_state_e state_q;
    logic        mode_auto_q;
    logic        hold_done;
    fseq_out_t   outs;

    fseq_req_merge u_merge (
        .ovld_req  (ovld_req_i),
        .ocp_req   (ocp_req_i),
        .therm_req (therm_req_i),
        .temp_ok   (temp_ok_i),
        .vcc_on    (vcc_on_i),
        .vcc_lo    (vcc_lo_i),
        .vcc_rst   (vcc_rst_i),
        .brown_out (brown_out_i),
        .pwr_save  (pwr_save_i),
        .req       (req)
    );

    fseq_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (state_q == ST_BHOLD),
        .done (hold_done)
    );

    fseq_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .auto_mode   (auto_mode_i),
        .hold_done   (hold_done),
        .state_q     (state_q),
        .mode_auto_q (mode_auto_q)
    );

    fseq_out_dec u_dec (
        .clk      (clk),
        .rst      (rst),
        .state_q  (state_q),
        .vcc_on   (vcc_on_i),
        .vcc_lo   (vcc_lo_i),
        .outs     (outs),
        .state_oh (state_oh_o)
    );

    assign drv_en_o     = outs.drv_en;
    assign bias_hold_o  = outs.bias_hold;
    assign charge_req_o = outs.charge_req;

    AST_DRIVE_OFF_AFTER_FAULT: assert property (@(posedge clk) disable iff (rst)
        (drv_en_o && (ovld_req_i || ocp_req_i || therm_req_i)) |=> !drv_en_o); // R11
    AST_NO_BIAS_WITH_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !(drv_en_o && (bias_hold_o || charge_req_o))); // R11
endmodule

// File: tb/prot_fault_seq_tb_top.sv
`timescale 1ns/1ps
module prot_fault_seq_tb_top;
    localparam int HOLD = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ovld = 0, ocp = 0, therm = 0, temp_ok = 0, auto_m = 0;
    logic vcc_on = 0, vcc_lo = 0, vcc_rst = 0, bo = 0, psave = 0;
    logic drv_en, bias_hold, charge_req;
    logic [5:0] state_oh;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    // Model state codes equal the one-hot bit index from R1
    localparam int M_RUN = 0, M_DIS = 1, M_BH = 2, M_CHG = 3, M_LAT = 4, M_TH = 5;
    int m_st = M_CHG;
    bit m_mode = 0;
    bit m_hic = 0;
    int m_cnt = 0;

    always #2 clk = ~clk;

    prot_fault_seq #(.HOLD_CYCLES(HOLD)) dut_i (
        .clk(clk), .rst(rst),
        .ovld_req_i(ovld), .ocp_req_i(ocp), .therm_req_i(therm), .temp_ok_i(temp_ok),
        .auto_mode_i(auto_m), .vcc_on_i(vcc_on), .vcc_lo_i(vcc_lo), .vcc_rst_i(vcc_rst),
        .brown_out_i(bo), .pwr_save_i(psave),
        .drv_en_o(drv_en), .bias_hold_o(bias_hold), .charge_req_o(charge_req),
        .state_oh_o(state_oh)
    );

    function automatic bit clean();
        return !(ovld || ocp || therm || bo);
    endfunction

    function automatic int next_st();
        if (vcc_rst) return M_CHG;
        case (m_st)
            M_RUN: return therm ? M_TH : ((ovld || ocp) ? M_DIS : M_RUN);
            M_DIS: return vcc_lo ? (m_mode ? M_BH : M_LAT) : M_DIS;
            M_BH:  return (m_cnt == HOLD - 1) ? M_CHG : M_BH;
            M_CHG: return therm ? M_TH : ((vcc_on && clean()) ? M_RUN : M_CHG);
            M_LAT: return M_LAT;
            default: return (bo || psave) ? M_CHG :
                            ((vcc_on && temp_ok && clean()) ? M_RUN : M_TH);
        endcase
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // One clock: model steps on the edge, outputs compared at the falling edge
    task automatic tick();
        int nx;
        @(posedge clk);
        if (rst) begin
            m_st = M_CHG; m_mode = 0; m_hic = 0; m_cnt = 0;
        end else begin
            nx = next_st();
            if (m_st == M_TH) m_hic = vcc_on ? 1'b0 : (vcc_lo ? 1'b1 : m_hic);
            else m_hic = 0;
            m_cnt = (m_st == M_BH && nx == M_BH) ? m_cnt + 1 : 0;
            if (m_st == M_RUN && nx == M_DIS) m_mode = auto_m;
            m_st = nx;
        end
        @(negedge clk);
        check("R1",  "state_oh", int'(state_oh), 1 << m_st);
        check("R11", "drv_en", int'(drv_en), int'(m_st == M_RUN));
        check("R4",  "bias_hold", int'(bias_hold), int'(m_st == M_BH || m_st == M_LAT));
        check("R6",  "charge_req", int'(charge_req), int'(m_st == M_CHG || (m_st == M_TH && m_hic)));
    endtask

    task automatic quiet();
        ovld = 0; ocp = 0; therm = 0; temp_ok = 0; vcc_on = 0;
        vcc_lo = 0; vcc_rst = 0; bo = 0; psave = 0;
    endtask

    task automatic expect_oh(string req, logic [5:0] exp);
        check(req, "state_oh", int'(state_oh), int'(exp));
    endtask

    initial begin : watchdog
        #400000;
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int n;
        void'($urandom(32'd20240611));
        rst = 1;
        repeat (3) tick();
        rst = 0;
        tick();
        expect_oh("R1", 6'b001000);
        check("R1", "charge_req after reset", int'(charge_req), 1);

        // R6: start gated by pending faults
        vcc_on = 1; ovld = 1; tick(); expect_oh("R6", 6'b001000);
        ovld = 0; bo = 1; tick(); expect_oh("R6", 6'b001000);
        bo = 0; tick(); expect_oh("R6", 6'b000001);
        check("R11", "drv_en in RUN", int'(drv_en), 1);

        // R7: thermal beats overload
        vcc_on = 0; ovld = 1; therm = 1; tick(); expect_oh("R7", 6'b100000);
        check("R11", "drv_en in THERMAL", int'(drv_en), 0);

        // R8 / R9: hiccup and cooled restart
        quiet(); vcc_lo = 1; tick();
        check("R8", "charge_req after vcc_lo", int'(charge_req), 1);
        vcc_lo = 0; vcc_on = 1; temp_ok = 0; tick();
        check("R8", "charge_req after vcc_on", int'(charge_req), 0);
        expect_oh("R9", 6'b100000);
        temp_ok = 1; tick(); expect_oh("R9", 6'b000001);

        // R2 / R3 / R4: latch-off captured, later mode flip ignored
        quiet(); auto_m = 0; ocp = 1; tick(); expect_oh("R2", 6'b000010);
        check("R2", "outputs in DISCHARGE", int'({drv_en, bias_hold, charge_req}), 0);
        ocp = 0; auto_m = 1; tick(); expect_oh("R2", 6'b000010);
        vcc_lo = 1; tick(); expect_oh("R3", 6'b010000);
        check("R4", "bias_hold latched", int'(bias_hold), 1);
        for (int i = 0; i < 12; i++) begin
            {ovld, ocp, therm, temp_ok, vcc_on, vcc_lo, bo, psave} = 8'($urandom);
            tick(); expect_oh("R4", 6'b010000);
        end

        // R10: reset level releases the latch
        quiet(); vcc_rst = 1; tick(); expect_oh("R10", 6'b001000);

        // R3 / R5: restart captured, hold length
        quiet(); vcc_on = 1; tick(); expect_oh("R6", 6'b000001);
        vcc_on = 0; auto_m = 1; ovld = 1; tick();
        ovld = 0; auto_m = 0; vcc_lo = 1; tick(); expect_oh("R3", 6'b000100);
        vcc_lo = 0;
        n = 0;
        while (bias_hold && n < 100) begin n++; tick(); end
        check("R5", "bias hold length", n, HOLD);
        expect_oh("R5", 6'b001000);

        // R9: power saving and brown-out clear thermal
        vcc_on = 1; tick(); vcc_on = 0; therm = 1; tick(); expect_oh("R7", 6'b100000);
        therm = 0; psave = 1; tick(); expect_oh("R9", 6'b001000);
        psave = 0; vcc_on = 1; tick(); vcc_on = 0; therm = 1; tick();
        therm = 0; bo = 1; tick(); expect_oh("R9", 6'b001000);

        // R10: reset level during the bias hold
        quiet(); vcc_on = 1; tick(); vcc_on = 0; auto_m = 1; ocp = 1; tick();
        ocp = 0; vcc_lo = 1; tick(); vcc_lo = 0; tick(); tick();
        vcc_rst = 1; tick(); expect_oh("R10", 6'b001000);

        // Random phase checked against the model every cycle
        quiet();
        for (int i = 0; i < 6000; i++) begin
            vcc_on  = ($urandom % 4) == 0;
            vcc_lo  = ($urandom % 4) == 0;
            vcc_rst = ($urandom % 60) == 0;
            bo      = ($urandom % 20) == 0;
            psave   = ($urandom % 20) == 0;
            ovld    = ($urandom % 10) == 0;
            ocp     = ($urandom % 10) == 0;
            therm   = ($urandom % 14) == 0;
            temp_ok = ($urandom % 2) == 0;
            auto_m  = ($urandom % 2) == 0;
            tick();
        end

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule